// File: doc/BRIEF.md
# Multiplexed GPIO Pin Controller

This block controls a bank of 32 general-purpose pins. Each pin is owned either by the GPIO function or by one of two internal peripheral functions, called A and B. A pin owned by GPIO has an output enable, an output data latch and an open-drain mode. A pull-up control applies to every pin. Every control bit changes only through a write-one-to-set strobe or a write-one-to-clear strobe, so software can change one pin without a read-modify-write. Each control group also has a status word that reads the stored bits back.

The pad level passes through a two-flop synchronizer and can be read whichever function owns the pin. The bus is a single-cycle register port. A write takes effect at the clock edge where `bus_we` is high. Read data is registered and shows the register addressed in the previous cycle.

Register map (byte addresses). Each group has three words: base+0x0 sets bits, base+0x4 clears bits, base+0x8 reads the status. The groups are:
- ownership at 0x00 (1 = GPIO);
- peripheral select at 0x10 (the set word selects B, the clear word selects A, status 1 = B);
- output enable at 0x20;
- output data latch at 0x30;
- pull-up at 0x40;
- open-drain at 0x50.

The synchronized pad level is read at 0x68. Pin n always uses bit n.

Top module: `pinmux_gpio_ctrl`

## Requirements
- R1: After reset, GPIO owns every pin, every output is disabled, every pull-up is on, open-drain is off everywhere, peripheral A is selected for every pin and the data latch is 0. The status words read 0xFFFFFFFF (ownership), 0 (select), 0 (output enable), 0 (data), 0xFFFFFFFF (pull-up) and 0 (open-drain).
- R2: Writing a mask to 0x00 gives the pins marked with 1 to GPIO. Writing a mask to 0x04 gives the marked pins to a peripheral. The status word at 0x08 has a 1 where GPIO owns the pin. Pins whose mask bit is 0 keep their state.
- R3: Writing a mask to 0x10 selects peripheral B for the marked pins, and writing a mask to 0x14 selects peripheral A. The status word at 0x18 reads 1 for B and 0 for A.
- R4: The output enable is set through 0x20 and cleared through 0x24, and the data latch is set through 0x30 and cleared through 0x34. Their status words are at 0x28 and 0x38. Mask bits that are 0 leave the matching pin unchanged.
- R5: Pull-up is set through 0x40 and cleared through 0x44, and its status word is at 0x48. `pad_pullup` equals the pull-up status for every pin, whichever function owns the pin.
- R6: On a pin that GPIO owns with open-drain off, `pad_out` equals the data latch and `pad_oe` equals the output enable.
- R7: Open-drain is set through 0x50 and cleared through 0x54, and its status word is at 0x58. On a pin that GPIO owns with open-drain on, `pad_out` is 0 and `pad_oe` is the output enable AND NOT the data latch, so the pad floats when the latch is 1.
- R8: On a pin owned by a peripheral, `pad_out` and `pad_oe` come from that pin's `periph_a_*` inputs when the select bit is 0, or from its `periph_b_*` inputs when the select bit is 1. The GPIO latches have no effect on such a pin.
- R9: The word at 0x68 returns `pad_in` after a two-flop synchronizer, for every pin, whichever function owns it.
- R10: `bus_rdata` is registered and shows the word addressed in the previous cycle. The set and clear addresses, and any unmapped address, read as 0. Writes to status addresses or unmapped addresses change no state.
- R11: A control write changes the pad outputs starting in the cycle after the write edge. The pad outputs do not change while the write is still being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Register byte address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Level to drive on each pad |
| pad_oe | output | 32 | Pad driver enable per pin |
| pad_pullup | output | 32 | Pull-up enable per pin |
| periph_a_out | input | 32 | Peripheral A output levels |
| periph_a_oe | input | 32 | Peripheral A driver enables |
| periph_b_out | input | 32 | Peripheral B output levels |
| periph_b_oe | input | 32 | Peripheral B driver enables |

## Verification
The cases that matter most are two events landing in the same cycle.

The first is an ownership change landing while the GPIO latches and both peripherals drive conflicting values on the same pins. The bench sets the GPIO latches to one pattern and holds the two peripheral input words at opposite alternating patterns. It then writes the ownership and select words. It checks that `pad_out` and `pad_oe` are unchanged while the write is still being presented, and that every pin takes its new source in the following cycle.

The second is a pad change arriving while a peripheral owns some of the pins. The bench reads the pad-level word at least three cycles after the change, which allows for the synchronizer latency.

// File: rtl/pinmux_pkg.sv
// Shared types and the register map of the multiplexed GPIO pin controller.
// Assumes byte addresses that are word aligned. Each group holds set, clear and status words.
package pinmux_pkg;

    localparam int unsigned PMX_GROUPS = 6;

    typedef enum logic [3:0] {
        GRP_OWN = 4'd0,
        GRP_SEL = 4'd1,
        GRP_OE  = 4'd2,
        GRP_DAT = 4'd3,
        GRP_PU  = 4'd4,
        GRP_MD  = 4'd5,
        GRP_PAD = 4'd6,
        GRP_BAD = 4'd15
    } pmx_group_e;

    typedef enum logic [1:0] {
        SUB_SET  = 2'd0,
        SUB_CLR  = 2'd1,
        SUB_STAT = 2'd2,
        SUB_NONE = 2'd3
    } pmx_sub_e;

    typedef struct packed {
        logic       hit;
        pmx_group_e grp;
        pmx_sub_e   sub;
    } pmx_decode_t;

    localparam logic [31:0] ADDR_OWN_SET  = 32'h0000_0000;
    localparam logic [31:0] ADDR_OWN_CLR  = 32'h0000_0004;
    localparam logic [31:0] ADDR_OWN_STAT = 32'h0000_0008;
    localparam logic [31:0] ADDR_SEL_SET  = 32'h0000_0010;
    localparam logic [31:0] ADDR_SEL_CLR  = 32'h0000_0014;
    localparam logic [31:0] ADDR_OE_SET   = 32'h0000_0020;
    localparam logic [31:0] ADDR_OE_CLR   = 32'h0000_0024;
    localparam logic [31:0] ADDR_DAT_SET  = 32'h0000_0030;
    localparam logic [31:0] ADDR_DAT_CLR  = 32'h0000_0034;
    localparam logic [31:0] ADDR_PAD_STAT = 32'h0000_0068;

    // Splits a byte address into group and word. hit is 0 for unmapped addresses.
    function automatic pmx_decode_t pmx_decode(input logic [31:0] addr);
        pmx_decode_t d;
        d.grp = pmx_group_e'({1'b0, addr[6:4]});
        d.sub = pmx_sub_e'(addr[3:2]);
        d.hit = (addr[31:7] == '0) && (addr[1:0] == 2'b00)
                && (addr[6:4] <= 3'd6) && (addr[3:2] != 2'b11);
        if (!d.hit) begin
            d.grp = GRP_BAD;
            d.sub = SUB_NONE;
        end
        return d;
    endfunction

endpackage

// File: rtl/pmx_setclr_reg.sv
// One control vector that only changes through set and clear masks.
// Assumes set and clear are never both high for the same bit in one cycle,
// which is true because the bus carries one write per cycle.
module pmx_setclr_reg #(
    parameter int unsigned W        = 32,
    parameter bit          RST_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);

    // Holds the vector and applies the marked bits on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= {W{RST_ONES}};
        else        q <= (q | set_mask) & ~clr_mask;
    end

endmodule

// File: rtl/pmx_regfile.sv
// Register file: decodes the bus and holds the six set/clear control groups.
// It also drives the registered read data, which includes the synchronized pad level.
// Assumes NPIN <= DW. Bits of a read above NPIN read as 0.
module pmx_regfile
    import pinmux_pkg::*;
#(
    parameter int unsigned NPIN = 32,
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pad_level,
    output logic [NPIN-1:0] own_q,
    output logic [NPIN-1:0] sel_q,
    output logic [NPIN-1:0] oe_q,
    output logic [NPIN-1:0] dat_q,
    output logic [NPIN-1:0] pu_q,
    output logic [NPIN-1:0] md_q
);

    pmx_decode_t     dec;
    logic [NPIN-1:0] ctrl [PMX_GROUPS];
    logic [DW-1:0]   rd_next;

    // Decodes the current bus address.
    always_comb begin
        dec = pmx_decode(32'(bus_addr));
    end

    for (genvar g = 0; g < PMX_GROUPS; g++) begin : g_ctl
        localparam bit ONES = (g == int'(GRP_OWN)) || (g == int'(GRP_PU));
        logic [NPIN-1:0] set_m;
        logic [NPIN-1:0] clr_m;

        // Routes the write mask to the set or clear strobe of this group.
        always_comb begin
            set_m = '0;
            clr_m = '0;
            if (bus_we && dec.hit && (dec.grp == pmx_group_e'(g))) begin
                if (dec.sub == SUB_SET) set_m = bus_wdata[NPIN-1:0];
                if (dec.sub == SUB_CLR) clr_m = bus_wdata[NPIN-1:0];
            end
        end

        pmx_setclr_reg #(.W(NPIN), .RST_ONES(ONES)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_m),
            .clr_mask (clr_m),
            .q        (ctrl[g])
        );
    end

    assign own_q = ctrl[GRP_OWN];
    assign sel_q = ctrl[GRP_SEL];
    assign oe_q  = ctrl[GRP_OE];
    assign dat_q = ctrl[GRP_DAT];
    assign pu_q  = ctrl[GRP_PU];
    assign md_q  = ctrl[GRP_MD];

    // Selects the status word for the addressed group. Every other address reads 0.
    always_comb begin
        rd_next = '0;
        if (dec.sub == SUB_STAT) begin
            case (dec.grp)
                GRP_OWN: rd_next[NPIN-1:0] = own_q;
                GRP_SEL: rd_next[NPIN-1:0] = sel_q;
                GRP_OE:  rd_next[NPIN-1:0] = oe_q;
                GRP_DAT: rd_next[NPIN-1:0] = dat_q;
                GRP_PU:  rd_next[NPIN-1:0] = pu_q;
                GRP_MD:  rd_next[NPIN-1:0] = md_q;
                GRP_PAD: rd_next[NPIN-1:0] = pad_level;
                default: rd_next = '0;
            endcase
        end
    end

    // Registers the read word, so data appears one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

endmodule

// File: rtl/pmx_sync.sv
// Multi-flop synchronizer for asynchronous pad levels.
// It has no reset on purpose: after reset it shows the pad at once,
// and a reset would add nothing to metastability settling.
module pmx_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    // Captures the raw pad level in the first flop.
    always_ff @(posedge clk) begin
        stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Moves the level one flop further along the chain.
        always_ff @(posedge clk) begin
            stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/pmx_pad_route.sv
// Per-pin output mux: GPIO (push-pull or open-drain), peripheral A or peripheral B.
// Purely combinational. It assumes the control vectors come straight from flops.
module pmx_pad_route #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] own_gpio,
    input  logic [W-1:0] sel_b,
    input  logic [W-1:0] gpio_oe,
    input  logic [W-1:0] gpio_dat,
    input  logic [W-1:0] gpio_md,
    input  logic [W-1:0] pa_out,
    input  logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_out,
    input  logic [W-1:0] pb_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic gp_out, gp_oe, pe_out, pe_oe;

        // GPIO driver: in open-drain mode the pad is driven low only when the latch is 0.
        always_comb begin
            if (gpio_md[i]) begin
                gp_out = 1'b0;
                gp_oe  = gpio_oe[i] & ~gpio_dat[i];
            end else begin
                gp_out = gpio_dat[i];
                gp_oe  = gpio_oe[i];
            end
        end

        // First mux level: picks peripheral A or peripheral B.
        always_comb begin
            pe_out = sel_b[i] ? pb_out[i] : pa_out[i];
            pe_oe  = sel_b[i] ? pb_oe[i]  : pa_oe[i];
        end

        // Second mux level: picks GPIO or the selected peripheral.
        always_comb begin
            pad_out[i] = own_gpio[i] ? gp_out : pe_out;
            pad_oe[i]  = own_gpio[i] ? gp_oe  : pe_oe;
        end
    end

endmodule

// File: rtl/pinmux_gpio_ctrl.sv
// Top of the multiplexed GPIO pin controller.
// It ties together the register file, the pad synchronizer and the per-pin output mux.
// Assumes one bus access per cycle and synchronous active-low reset.
module pinmux_gpio_ctrl #(
    parameter int unsigned NPIN        = 32,
    parameter int unsigned AW          = 32,
    parameter int unsigned DW          = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pullup,
    input  logic [NPIN-1:0] periph_a_out,
    input  logic [NPIN-1:0] periph_a_oe,
    input  logic [NPIN-1:0] periph_b_out,
    input  logic [NPIN-1:0] periph_b_oe
);

    logic [NPIN-1:0] own_q, sel_q, oe_q, dat_q, pu_q, md_q;
    logic [NPIN-1:0] pad_level;

    pmx_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pad_in),
        .q   (pad_level)
    );

    pmx_regfile #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_level (pad_level),
        .own_q     (own_q),
        .sel_q     (sel_q),
        .oe_q      (oe_q),
        .dat_q     (dat_q),
        .pu_q      (pu_q),
        .md_q      (md_q)
    );

    pmx_pad_route #(.W(NPIN)) u_route (
        .own_gpio (own_q),
        .sel_b    (sel_q),
        .gpio_oe  (oe_q),
        .gpio_dat (dat_q),
        .gpio_md  (md_q),
        .pa_out   (periph_a_out),
        .pa_oe    (periph_a_oe),
        .pb_out   (periph_b_out),
        .pb_oe    (periph_b_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    assign pad_pullup = pu_q;

endmodule

// File: rtl/pmx_checker.sv
// Property checker for the multiplexed GPIO pin controller, bound to the top.
module pmx_checker
    import pinmux_pkg::*;
#(
    parameter int unsigned NPIN = 32,
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_we,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [NPIN-1:0] pad_in,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] periph_a_out,
    input logic [NPIN-1:0] periph_a_oe,
    input logic [NPIN-1:0] periph_b_out,
    input logic [NPIN-1:0] periph_b_oe,
    input logic [NPIN-1:0] own_q,
    input logic [NPIN-1:0] sel_q,
    input logic [NPIN-1:0] oe_q,
    input logic [NPIN-1:0] dat_q,
    input logic [NPIN-1:0] md_q,
    input logic [NPIN-1:0] pad_level
);

    assert_own_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && 32'(bus_addr) == ADDR_OWN_SET)
        |=> (own_q == ($past(own_q) | $past(bus_wdata[NPIN-1:0]))));

    assert_own_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && 32'(bus_addr) == ADDR_OWN_CLR)
        |=> (own_q == ($past(own_q) & ~$past(bus_wdata[NPIN-1:0]))));

    assert_sel_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && 32'(bus_addr) == ADDR_SEL_SET)
        |=> (sel_q == ($past(sel_q) | $past(bus_wdata[NPIN-1:0]))));

    assert_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (32'(bus_addr) == ADDR_OE_SET || 32'(bus_addr) == ADDR_OE_CLR))
        |=> $stable(oe_q));

    assert_open_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_q & md_q & dat_q & pad_oe) == '0));

    assert_periph_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~own_q & ~sel_q & ((pad_out ^ periph_a_out) | (pad_oe ^ periph_a_oe))) == '0));

    assert_periph_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~own_q & sel_q & ((pad_out ^ periph_b_out) | (pad_oe ^ periph_b_oe))) == '0));

    assert_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pad_level == $past(pad_in, 2));

    assert_wo_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr) == ADDR_OWN_SET || 32'(bus_addr) == ADDR_DAT_CLR)
        |=> (bus_rdata == '0));

    assert_stat_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && 32'(bus_addr) == ADDR_OWN_STAT) |=> $stable(own_q));

endmodule

bind pinmux_gpio_ctrl pmx_checker #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_pmx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .periph_a_out (periph_a_out),
    .periph_a_oe  (periph_a_oe),
    .periph_b_out (periph_b_out),
    .periph_b_oe  (periph_b_oe),
    .own_q        (own_q),
    .sel_q        (sel_q),
    .oe_q         (oe_q),
    .dat_q        (dat_q),
    .md_q         (md_q),
    .pad_level    (pad_level)
);

// File: tb/test_pinmux_gpio_ctrl.sv
// Scoreboard bench: read tasks queue expected words, and a monitor compares them
// against bus_rdata one cycle later. Pad outputs are compared with a model built
// from the requirements.
module test_pinmux_gpio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, pad_pullup;
    logic [31:0] periph_a_out = 32'hAAAA_AAAA;
    logic [31:0] periph_a_oe  = 32'hFFFF_0000;
    logic [31:0] periph_b_out = 32'h5555_5555;
    logic [31:0] periph_b_oe  = 32'h0000_FFFF;

    int checks = 0;
    int errors = 0;

    // Model state, written from the requirement text.
    logic [31:0] m_own = 32'hFFFF_FFFF, m_sel = '0, m_oe = '0, m_dat = '0;
    logic [31:0] m_pu = 32'hFFFF_FFFF, m_md = '0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_issue = 1'b0;
    logic        rd_issue_q = 1'b0;

    always #10 clk = ~clk;

    pinmux_gpio_ctrl i_pinmux_gpio_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .pad_pullup   (pad_pullup),
        .periph_a_out (periph_a_out),
        .periph_a_oe  (periph_a_oe),
        .periph_b_out (periph_b_out),
        .periph_b_oe  (periph_b_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: remembers that a read was issued at this edge.
    always @(posedge clk) rd_issue_q <= rd_issue;

    // Monitor: compares the registered read data against the next queued word.
    always @(negedge clk) begin
        if (rd_issue_q) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10 unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic model_write(input logic [31:0] a, input logic [31:0] d);
        case (a)
            32'h00: m_own = m_own | d;
            32'h04: m_own = m_own & ~d;
            32'h10: m_sel = m_sel | d;
            32'h14: m_sel = m_sel & ~d;
            32'h20: m_oe  = m_oe | d;
            32'h24: m_oe  = m_oe & ~d;
            32'h30: m_dat = m_dat | d;
            32'h34: m_dat = m_dat & ~d;
            32'h40: m_pu  = m_pu | d;
            32'h44: m_pu  = m_pu & ~d;
            32'h50: m_md  = m_md | d;
            32'h54: m_md  = m_md & ~d;
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        rd_issue = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_issue = 1'b0;
    endtask

    function automatic logic [31:0] exp_out();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            if (m_own[i])      r[i] = m_md[i] ? 1'b0 : m_dat[i];
            else if (m_sel[i]) r[i] = periph_b_out[i];
            else               r[i] = periph_a_out[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_oe();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            if (m_own[i])      r[i] = m_md[i] ? (m_oe[i] & ~m_dat[i]) : m_oe[i];
            else if (m_sel[i]) r[i] = periph_b_oe[i];
            else               r[i] = periph_a_oe[i];
        end
        return r;
    endfunction

    task automatic check_pads(input string tag);
        check({tag, " pad_out"}, pad_out, exp_out());
        check({tag, " pad_oe"}, pad_oe, exp_oe());
        check({tag, " pad_pullup"}, pad_pullup, m_pu);
    endtask

    task automatic read_all(input string tag);
        bus_read(32'h08, m_own, {tag, " own"});
        bus_read(32'h18, m_sel, {tag, " sel"});
        bus_read(32'h28, m_oe,  {tag, " oe"});
        bus_read(32'h38, m_dat, {tag, " dat"});
        bus_read(32'h48, m_pu,  {tag, " pu"});
        bus_read(32'h58, m_md,  {tag, " md"});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check_pads("R1 reset");
        read_all("R1 reset");
        check("R1 literal oe", pad_oe, 32'h0);

        // R4: output enable and data latch; mask bits at 0 keep their state
        bus_write(32'h20, 32'h0000_00FF);
        bus_write(32'h30, 32'h0000_000F);
        bus_write(32'h34, 32'h0000_0003);
        read_all("R4 set/clear");
        check("R4 literal dat pins", pad_out[7:0], 8'h0C);
        check_pads("R6 push-pull");

        // R7: open-drain, both latch states
        bus_write(32'h50, 32'h0000_00F0);
        check_pads("R7 od latch0");
        bus_write(32'h30, 32'h0000_0030);
        check("R7 literal oe", pad_oe[7:0], 8'hCF);
        check_pads("R7 od latch1");
        bus_read(32'h58, 32'h0000_00F0, "R7 md status");
        bus_write(32'h54, 32'h0000_0010);
        check_pads("R7 md cleared pin4");

        // R5: pull-up clear/set
        bus_write(32'h44, 32'hFFFF_0000);
        check_pads("R5 pu clear");
        bus_write(32'h40, 32'h0100_0000);
        bus_read(32'h48, 32'h0100_FFFF, "R5 pu status");

        // R8 and R11: ownership handover while the latches conflict with both peripherals
        bus_write(32'h30, 32'h0000_0F00);
        bus_write(32'h20, 32'h0000_0F00);
        bus_write(32'h10, 32'h0000_0202);
        @(negedge clk);
        bus_addr = 32'h04; bus_we = 1'b1; bus_wdata = 32'h0000_0303;
        #1;
        check_pads("R11 before edge");
        @(negedge clk);
        bus_we = 1'b0;
        model_write(32'h04, 32'h0000_0303);
        check_pads("R8 R11 after handover");
        read_all("R2 R3 handover");

        // R8: changing the peripheral inputs moves only the peripheral-owned pins
        periph_a_out = 32'h0F0F_0F0F;
        periph_b_oe  = 32'hFFFF_FFFF;
        #1;
        check_pads("R8 periph change");

        // R2: give one pin back; R3: select A again for one pin
        bus_write(32'h00, 32'h0000_0001);
        bus_write(32'h14, 32'h0000_0200);
        read_all("R2 R3 partial");
        check_pads("R8 after partial");

        // R10: write-only and unmapped reads return 0; ignored writes
        bus_write(32'h08, 32'h0000_0000);
        bus_write(32'h70, 32'hFFFF_FFFF);
        bus_write(32'h0000_1020, 32'hFFFF_FFFF);
        read_all("R10 ignored writes");
        bus_read(32'h00, 32'h0, "R10 set word reads 0");
        bus_read(32'h34, 32'h0, "R10 clear word reads 0");
        bus_read(32'h74, 32'h0, "R10 unmapped reads 0");
        check_pads("R10 pads unchanged");

        // R9: pad level through the synchronizer, including peripheral-owned pins
        @(negedge clk);
        pad_in = 32'h1234_5678;
        repeat (3) @(negedge clk);
        bus_read(32'h68, 32'h1234_5678, "R9 pad level");
        @(negedge clk);
        pad_in = 32'hFFFF_0303;
        repeat (3) @(negedge clk);
        bus_read(32'h68, 32'hFFFF_0303, "R9 pad level periph pins");

        repeat (3) @(negedge clk);
        check("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule